// File: doc/BRIEF.md
# Total-Store-Order Write Buffer with Load Forwarding

This block sits between a core's retirement stage and its first-level data cache. Each retired store is captured with its address, data and byte-enable mask into a small circular queue. The queue writes them to the cache write port one at a time, strictly oldest first. The cache may hold off a write for as long as it needs by lowering its ready signal. Because stores reach the cache only in program order, other observers see every core's stores in the order they were issued. The one ordering that is relaxed is that a later load may complete before an older store.

Every load the core presents is compared, in the same cycle, against the buffered stores. If no buffered store writes any byte the load reads, the load goes straight to the cache, ahead of the older stores. If the youngest overlapping store supplies every byte the load needs, that store's data is returned directly. If the youngest overlapping store only covers some of the bytes, the load is held until that store has drained. A full fence, held by the core until it is acknowledged, stops all younger loads and stores until the queue is empty.

Top module: `tso_store_buffer`

## Requirements
- R1: Coming out of reset, the queue is empty: `sb_empty` is 1, `cw_valid` is 0 and `st_ready` is 1.
- R2: Accepted stores are presented on the cache write port in exactly the order they were accepted. Each one is presented once, with its address, data and byte mask unchanged. One entry is removed for each cycle in which `cw_valid` and `cw_ready` are both high.
- R3: While `cw_valid` is high and `cw_ready` is low, `cw_valid`, `cw_addr`, `cw_data` and `cw_be` hold their values into the next cycle.
- R4: When DEPTH stores are held, `st_ready` is 0. A store offered while `st_ready` is 0 is not taken and never reaches the cache port.
- R5: A load that has no byte in common with any buffered store (same address and at least one common byte-enable bit) gets `ld_go_cache` = 1 in the same cycle, even while older stores are still waiting.
- R6: A load whose youngest overlapping store enables every byte the load enables gets `ld_fwd` = 1 in the same cycle. `ld_fwd_data` then carries that store's bytes in the lanes the load enables and zero in the other lanes, where byte lane k is bits 8k+7..8k.
- R7: When more than one buffered store overlaps a load, the forwarded data comes from the most recently accepted of them.
- R8: A load whose youngest overlapping store does not enable all of the load's bytes gets `ld_stall` = 1. This holds even if an older store covers those bytes. Once that store has drained, and nothing else overlaps the load, the same load goes to the cache.
- R9: A buffered store to the same address whose byte mask shares no bit with the load's mask does not count as overlapping. It is skipped when the forwarding source is chosen.
- R10: While `fence_req` is high and the queue is not empty, `fence_ack` is 0, `st_ready` is 0, and any load gets `ld_stall` rather than going to the cache or being forwarded. `fence_ack` is 1 in every cycle in which `fence_req` is high and the queue is empty.
- R11: `sb_empty` is 1 exactly when no store is held. It goes from 0 to 1 only in the cycle after the last entry is written to the cache.
- R12: With `ld_valid` high, exactly one of `ld_go_cache`, `ld_fwd` and `ld_stall` is 1. With `ld_valid` low, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| st_valid | input | 1 | A retired store is offered |
| st_ready | output | 1 | The store is accepted on this cycle's edge |
| st_addr | input | AW | Store address (word granular) |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| ld_valid | input | 1 | A load is looking up the buffer |
| ld_addr | input | AW | Load address |
| ld_be | input | DW/8 | Bytes the load reads |
| ld_go_cache | output | 1 | The load may read the cache now |
| ld_fwd | output | 1 | The load is served from the buffer |
| ld_fwd_data | output | DW | Forwarded data, with disabled lanes set to zero |
| ld_stall | output | 1 | The load must retry in a later cycle |
| fence_req | input | 1 | A full fence is pending; held high until acknowledged |
| fence_ack | output | 1 | The fence is complete |
| cw_valid | output | 1 | The oldest store is offered to the cache |
| cw_ready | input | 1 | The cache takes the write on this edge |
| cw_addr | output | AW | Cache write address |
| cw_data | output | DW | Cache write data |
| cw_be | output | DW/8 | Cache write byte enables |
| sb_empty | output | 1 | No store is held |

## Verification
The bench builds the buffer with DEPTH = 4, a 16-bit address and a 32-bit data path with four byte lanes. With only four entries, the full condition and the refusal of a fifth store take only a handful of cycles to reach. The successive scenarios also push the head and tail pointers around the ring several times, so the search for the youngest overlapping store is exercised both with and without wrap-around. The four byte lanes are enough to build overlaps that are complete, partial and disjoint at a single address.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Outcome of a load lookup against the buffered stores.
  typedef enum logic [1:0] {
    LK_CACHE = 2'd0,
    LK_FWD   = 2'd1,
    LK_STALL = 2'd2
  } lookup_e;

endpackage

// File: rtl/sb_queue.sv
module sb_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 64,
  localparam int BW   = DW / 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push_i,
  input  logic [AW-1:0]                  push_addr_i,
  input  logic [DW-1:0]                  push_data_i,
  input  logic [BW-1:0]                  push_be_i,
  input  logic                           pop_i,
  output logic [DEPTH-1:0]               ent_vld_o,
  output logic [DEPTH-1:0][AW-1:0]       ent_addr_o,
  output logic [DEPTH-1:0][DW-1:0]       ent_data_o,
  output logic [DEPTH-1:0][BW-1:0]       ent_be_o,
  output logic [PW-1:0]                  head_o,
  output logic [AW-1:0]                  head_addr_o,
  output logic [DW-1:0]                  head_data_o,
  output logic [BW-1:0]                  head_be_o,
  output logic                           full_o,
  output logic                           empty_o
);

  logic [PW-1:0]          head_q, head_d;
  logic [PW-1:0]          tail_q, tail_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic [DEPTH-1:0]       vld_q, vld_d;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  logic [DEPTH-1:0][BW-1:0] be_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  // Next-state logic for pointers, occupancy and valid bits.
  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    vld_d  = vld_q;
    if (push_i) begin
      vld_d[tail_q] = 1'b1;
      tail_d        = bump(tail_q);
    end
    if (pop_i) begin
      vld_d[head_q] = 1'b0;
      head_d        = bump(head_q);
    end
    unique case ({push_i, pop_i})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  // Control registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      vld_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
      vld_q  <= vld_d;
    end
  end

  // Payload storage: no reset, written under a clock enable.
  always_ff @(posedge clk) begin
    if (push_i) begin
      addr_q[tail_q] <= push_addr_i;
      data_q[tail_q] <= push_data_i;
      be_q[tail_q]   <= push_be_i;
    end
  end

  assign ent_vld_o   = vld_q;
  assign ent_addr_o  = addr_q;
  assign ent_data_o  = data_q;
  assign ent_be_o    = be_q;
  assign head_o      = head_q;
  assign head_addr_o = addr_q[head_q];
  assign head_data_o = data_q[head_q];
  assign head_be_o   = be_q[head_q];
  assign full_o      = (cnt_q == CW'(DEPTH));
  assign empty_o     = (cnt_q == '0);

  // R4: the queue is never written while it holds DEPTH entries.
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);

  // R2: an entry is only removed when one is held.
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);

  // R11: the queue becomes empty only through a removal.
  a_r11_empty_by_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_o && !push_i && pop_i && $countones(vld_q) == 1) |=> empty_o);

  // R2: the slot at the head is always occupied while anything is held.
  a_r2_head_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_o |-> vld_q[head_q]);

endmodule

// File: rtl/sb_lookup.sv
module sb_lookup
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 64,
  localparam int BW   = DW / 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]          ent_vld_i,
  input  logic [DEPTH-1:0][AW-1:0]  ent_addr_i,
  input  logic [DEPTH-1:0][DW-1:0]  ent_data_i,
  input  logic [DEPTH-1:0][BW-1:0]  ent_be_i,
  input  logic [PW-1:0]             head_i,
  input  logic [AW-1:0]             ld_addr_i,
  input  logic [BW-1:0]             ld_be_i,
  output lookup_e                   kind_o,
  output logic [DW-1:0]             fwd_data_o
);

  logic [DEPTH-1:0] overlap;
  logic             found;
  logic [PW-1:0]    sel;
  logic [DW-1:0]    sel_data;
  logic [BW-1:0]    sel_be;

  // One comparator per slot: same word and at least one shared byte.
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign overlap[g] = ent_vld_i[g] && (ent_addr_i[g] == ld_addr_i)
                        && |(ent_be_i[g] & ld_be_i);
  end

  // Walk from oldest to youngest; the last overlapping slot wins.
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      int j;
      j = int'(head_i) + i;
      if (j >= DEPTH) j = j - DEPTH;
      if (overlap[PW'(j)]) begin
        found = 1'b1;
        sel   = PW'(j);
      end
    end
  end

  assign sel_data = ent_data_i[sel];
  assign sel_be   = ent_be_i[sel];

  for (genvar b = 0; b < BW; b++) begin : g_lane
    assign fwd_data_o[8*b +: 8] = ld_be_i[b] ? sel_data[8*b +: 8] : 8'h00;
  end

  always_comb begin
    if (!found)                          kind_o = LK_CACHE;
    else if ((ld_be_i & ~sel_be) == '0)  kind_o = LK_FWD;
    else                                 kind_o = LK_STALL;
  end

endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 64,
  localparam int BW   = DW / 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [BW-1:0] st_be,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [BW-1:0] ld_be,
  output logic          ld_go_cache,
  output logic          ld_fwd,
  output logic [DW-1:0] ld_fwd_data,
  output logic          ld_stall,
  input  logic          fence_req,
  output logic          fence_ack,
  output logic          cw_valid,
  input  logic          cw_ready,
  output logic [AW-1:0] cw_addr,
  output logic [DW-1:0] cw_data,
  output logic [BW-1:0] cw_be,
  output logic          sb_empty
);

  logic                      push, pop, full, empty;
  logic [DEPTH-1:0]          ent_vld;
  logic [DEPTH-1:0][AW-1:0]  ent_addr;
  logic [DEPTH-1:0][DW-1:0]  ent_data;
  logic [DEPTH-1:0][BW-1:0]  ent_be;
  logic [PW-1:0]             head;
  lookup_e                   kind;

  assign st_ready = !full && !fence_req;
  assign push     = st_valid && st_ready;
  assign cw_valid = !empty;
  assign pop      = cw_valid && cw_ready;

  sb_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_queue (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push),
    .push_addr_i (st_addr),
    .push_data_i (st_data),
    .push_be_i   (st_be),
    .pop_i       (pop),
    .ent_vld_o   (ent_vld),
    .ent_addr_o  (ent_addr),
    .ent_data_o  (ent_data),
    .ent_be_o    (ent_be),
    .head_o      (head),
    .head_addr_o (cw_addr),
    .head_data_o (cw_data),
    .head_be_o   (cw_be),
    .full_o      (full),
    .empty_o     (empty)
  );

  sb_lookup #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_lookup (
    .ent_vld_i  (ent_vld),
    .ent_addr_i (ent_addr),
    .ent_data_i (ent_data),
    .ent_be_i   (ent_be),
    .head_i     (head),
    .ld_addr_i  (ld_addr),
    .ld_be_i    (ld_be),
    .kind_o     (kind),
    .fwd_data_o (ld_fwd_data)
  );

  // A pending fence overrides every lookup result.
  assign ld_go_cache = ld_valid && !fence_req && (kind == LK_CACHE);
  assign ld_fwd      = ld_valid && !fence_req && (kind == LK_FWD);
  assign ld_stall    = ld_valid && (fence_req || (kind == LK_STALL));
  assign fence_ack   = fence_req && empty;
  assign sb_empty    = empty;

  // R12: each presented load resolves one way only.
  a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $onehot({ld_go_cache, ld_fwd, ld_stall}));

  a_r12_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> !(ld_go_cache || ld_fwd || ld_stall));

  // R10: an unfinished fence blocks younger operations.
  a_r10_fence_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_req && !sb_empty) |-> (!st_ready && !ld_go_cache && !ld_fwd && !fence_ack));

  // R3: a stalled cache write holds its payload.
  a_r3_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && !cw_ready) |=> (cw_valid && $stable(cw_addr)
                                 && $stable(cw_data) && $stable(cw_be)));

  // R4: nothing is accepted while all entries are taken.
  a_r4_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> !st_ready);

endmodule

// File: tb/test_tso_store_buffer.sv
module test_tso_store_buffer;

  localparam int DEPTH = 4;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int BW    = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          st_valid, st_ready;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;
  logic [BW-1:0] st_be;
  logic          ld_valid, ld_go_cache, ld_fwd, ld_stall;
  logic [AW-1:0] ld_addr;
  logic [BW-1:0] ld_be;
  logic [DW-1:0] ld_fwd_data;
  logic          fence_req, fence_ack;
  logic          cw_valid, cw_ready;
  logic [AW-1:0] cw_addr;
  logic [DW-1:0] cw_data;
  logic [BW-1:0] cw_be;
  logic          sb_empty;

  always #4 clk = ~clk;

  tso_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_tso_store_buffer (
    .clk, .rst_n, .st_valid, .st_ready, .st_addr, .st_data, .st_be,
    .ld_valid, .ld_addr, .ld_be, .ld_go_cache, .ld_fwd, .ld_fwd_data, .ld_stall,
    .fence_req, .fence_ack, .cw_valid, .cw_ready, .cw_addr, .cw_data, .cw_be,
    .sb_empty
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Log of writes seen on the cache port.
  logic [AW-1:0] lg_addr [0:63];
  logic [DW-1:0] lg_data [0:63];
  logic [BW-1:0] lg_be   [0:63];
  int            lg_n = 0;

  always @(negedge clk) begin
    #3;
    if (rst_n && cw_valid && cw_ready && lg_n < 64) begin
      lg_addr[lg_n] = cw_addr;
      lg_data[lg_n] = cw_data;
      lg_be[lg_n]   = cw_be;
      lg_n++;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put_store(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [BW-1:0] be);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
    #1;
    while (!st_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic look(input logic [AW-1:0] a, input logic [BW-1:0] be,
                      output logic c, output logic f, output logic s,
                      output logic [DW-1:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_be = be;
    #1;
    c = ld_go_cache; f = ld_fwd; s = ld_stall; d = ld_fwd_data;
    ld_valid = 1'b0;
  endtask

  task automatic drain_all();
    @(negedge clk);
    cw_ready = 1'b1;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      #1;
      if (sb_empty) break;
    end
    cw_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "sb_empty", sb_empty, 1);
    chk("R1", "cw_valid", cw_valid, 0);
    chk("R1", "st_ready", st_ready, 1);
    chk("R12", "outcomes idle", {ld_go_cache, ld_fwd, ld_stall}, 0);
  endtask

  task automatic t_fifo_order();
    int base = lg_n;
    put_store(16'h0100, 32'h11111111, 4'b1111);
    put_store(16'h0200, 32'h22222222, 4'b0011);
    put_store(16'h0100, 32'h33333333, 4'b1100);
    #1;
    chk("R11", "not empty", sb_empty, 0);
    drain_all();
    chk("R2", "write count", lg_n - base, 3);
    chk("R2", "w0 addr", lg_addr[base], 16'h0100);
    chk("R2", "w0 data", lg_data[base], 32'h11111111);
    chk("R2", "w1 addr", lg_addr[base+1], 16'h0200);
    chk("R2", "w1 be", lg_be[base+1], 4'b0011);
    chk("R2", "w2 data", lg_data[base+2], 32'h33333333);
    chk("R2", "w2 be", lg_be[base+2], 4'b1100);
    chk("R11", "empty after drain", sb_empty, 1);
  endtask

  task automatic t_hold();
    put_store(16'h0300, 32'hAAAA0001, 4'b1111);
    put_store(16'h0304, 32'hAAAA0002, 4'b0101);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      chk("R3", "held addr", cw_addr, 16'h0300);
      chk("R3", "held data", cw_data, 32'hAAAA0001);
    end
    @(negedge clk);
    cw_ready = 1'b1;
    @(negedge clk);
    cw_ready = 1'b0;
    #1;
    chk("R3", "next addr after one write", cw_addr, 16'h0304);
    chk("R3", "next be after one write", cw_be, 4'b0101);
    drain_all();
  endtask

  task automatic t_full();
    int base = lg_n;
    for (int k = 0; k < DEPTH; k++)
      put_store(16'h0500 + 16'(k), 32'hF0000000 + 32'(k), 4'b1111);
    #1;
    chk("R4", "st_ready when full", st_ready, 0);
    @(negedge clk);
    st_valid = 1'b1; st_addr = 16'h0999; st_data = 32'h99999999; st_be = 4'b1111;
    @(negedge clk);
    @(negedge clk);
    st_valid = 1'b0;
    drain_all();
    chk("R4", "writes after full", lg_n - base, DEPTH);
    chk("R4", "last write is last accepted", lg_addr[base+DEPTH-1], 16'h0503);
  endtask

  task automatic t_bypass();
    logic c, f, s;
    logic [DW-1:0] d;
    put_store(16'h0400, 32'hDEADBEEF, 4'b1111);
    look(16'h0410, 4'b1111, c, f, s, d);
    chk("R5", "non-aliasing load to cache", c, 1);
    chk("R12", "single outcome", {c, f, s}, 3'b100);
    look(16'h0400, 4'b0110, c, f, s, d);
    chk("R6", "covered load forwarded", f, 1);
    chk("R6", "forwarded lanes", d, 32'h00ADBE00);
    drain_all();
  endtask

  task automatic t_youngest();
    logic c, f, s;
    logic [DW-1:0] d;
    put_store(16'h0600, 32'h11223344, 4'b1111);
    put_store(16'h0600, 32'h55667788, 4'b1111);
    put_store(16'h0700, 32'h01020304, 4'b1111);
    look(16'h0600, 4'b1111, c, f, s, d);
    chk("R7", "forward flag", f, 1);
    chk("R7", "youngest data", d, 32'h55667788);
    drain_all();
  endtask

  task automatic t_partial();
    logic c, f, s;
    logic [DW-1:0] d;
    put_store(16'h0800, 32'hCAFEF00D, 4'b1111);
    put_store(16'h0800, 32'h0000ABCD, 4'b0011);
    look(16'h0800, 4'b1111, c, f, s, d);
    chk("R8", "youngest partial stalls", s, 1);
    look(16'h0800, 4'b1100, c, f, s, d);
    chk("R9", "disjoint younger skipped", f, 1);
    chk("R9", "older data used", d, 32'hCAFE0000);
    look(16'h0800, 4'b0011, c, f, s, d);
    chk("R7", "low lanes from youngest", d, 32'h0000ABCD);
    put_store(16'h0900, 32'h00005555, 4'b0011);
    look(16'h0900, 4'b1100, c, f, s, d);
    chk("R9", "disjoint only goes to cache", c, 1);
    drain_all();
    look(16'h0800, 4'b1111, c, f, s, d);
    chk("R8", "after drain goes to cache", c, 1);
  endtask

  task automatic t_fence();
    logic c, f, s;
    logic [DW-1:0] d;
    put_store(16'h0A00, 32'h0000000A, 4'b1111);
    put_store(16'h0A04, 32'h0000000B, 4'b1111);
    @(negedge clk);
    fence_req = 1'b1;
    #1;
    chk("R10", "no ack while held", fence_ack, 0);
    chk("R10", "stores blocked", st_ready, 0);
    look(16'h0B00, 4'b1111, c, f, s, d);
    chk("R10", "younger load stalls", {c, f, s}, 3'b001);
    drain_all();
    chk("R10", "ack once empty", fence_ack, 1);
    @(negedge clk);
    fence_req = 1'b0;
    #1;
    chk("R10", "stores resume", st_ready, 1);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0; st_be = '0;
    ld_valid = 1'b0; ld_addr = '0; ld_be = '0; fence_req = 1'b0; cw_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_fifo_order();
    t_hold();
    t_full();
    t_bypass();
    t_youngest();
    t_partial();
    t_fence();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule